// File: doc/BRIEF.md
# Circular Request List Controller

This block is the device-side engine for two host-resident rings: an inbound list of request descriptors and an outbound list of completion words. Each ring runs over indices 0 to the configured entry count minus one and then wraps. Software advances an inbound write pointer to mark the newest filled descriptor. The controller walks the ring one descriptor at a time through a memory read port and presents the packet address and size to a completion model. It then waits for that model's flag, marks the flag with host-ownership bits, and writes it into the next outbound slot. After that it stores the slot number in a copy-pointer shadow word in host memory and sets an interrupt cause bit.

Software finds completions by comparing the shadow index with its own saved read index and reports that index back, so the controller never overruns unread completions. A separate mailbox carries non-queued commands. Software writes a message word, the embedded processor receives it as a one-cycle strobe, and the command counts as finished when the processor returns the same value.

Top module: `req_ring_ctl`

## Requirements
- R1: After reset no memory read, memory write or request is issued, irq is low, and the write pointer (0x08) and interrupt cause (0x24) registers read 0.
- R2: A write to the ring configuration register (0x0C; bit 31 enable, bits [IDX_W:0] entry count) sets the inbound write pointer, the internal fetch index, the outbound index and the host read index (0x20) all to count-1.
- R3: While enabled, descriptors are fetched one at a time, in order, from the index after the last fetched one up to and including the write pointer (0x08), wrapping from count-1 to 0. Descriptor i is read at inbound base (0x00 low, 0x04 high) + 8*i.
- R4: A fetched 64-bit descriptor holds the packet address in bits [31:0] and the size in bits [63:32]. These are presented with reqValid together with the descriptor index, and they stay stable until cplValid.
- R5: A completion writes cplFlag OR HOST_MASK to outbound base (0x10 low, 0x14 high) + 4*slot. The slot is the one after the previous completion slot and wraps at the count.
- R6: In the cycle after each completion word write, the slot index, zero-extended to 32 bits, is written to the shadow address (0x18 low, 0x1C high).
- R7: No completion word is written while the next slot equals the host read index (0x20). Writing resumes once that register moves.
- R8: Interrupt cause (0x24) bit 0 sets one cycle after a shadow write, and bit 1 sets one cycle after a processor reply equal to the pending message. Writing 1 to a cause bit clears it. irq is the OR of cause AND enable (0x28), and it follows one cycle after any such change.
- R9: A write to the message register (0x2C) gives one cpuMsgValid pulse carrying that value in the next cycle, and the register reads it back. A processor reply is readable at 0x30.
- R10: With enable at 0, moving the write pointer causes no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regAddr, same cycle |
| memRdEn | output | 1 | Descriptor read request, one cycle |
| memRdAddr | output | 64 | Descriptor address |
| memRdValid | input | 1 | Descriptor data valid |
| memRdData | input | 64 | Descriptor data |
| reqValid | output | 1 | Descriptor presented to the completion model |
| reqIdx | output | IDX_W | Descriptor index |
| reqAddr | output | 32 | Packet address |
| reqSize | output | 32 | Packet size |
| cplValid | input | 1 | Completion from the model, taken while reqValid |
| cplFlag | input | 32 | Request flag returned by the model |
| memWrEn | output | 1 | Host memory write, one cycle |
| memWrAddr | output | 64 | Write address |
| memWrData | output | 32 | Write data |
| cpuMsgValid | output | 1 | New message for the processor |
| cpuMsgData | output | 32 | Message value |
| cpuRplWe | input | 1 | Processor reply write |
| cpuRplData | input | 32 | Processor reply value |
| irq | output | 1 | Interrupt to the host |

## Verification
Register reads are combinational and due in the same cycle. A message strobe and any cause or irq change are due one cycle after the write, reply or shadow write that caused them. The descriptor data arrives two cycles after memRdEn, and the completion model answers three cycles after reqValid first appears. The monitor samples every port on the falling edge and applies each stimulus to its model only after comparing that cycle's outputs, so each expectation lands exactly one edge later. The full-ring stall and the disabled ring are checked by counting port events over a window.

// File: rtl/req_ring_pkg.sv
`timescale 1ns/1ps
package req_ring_pkg;
  localparam logic [7:0] OFS_IN_BASE_LO  = 8'h00;
  localparam logic [7:0] OFS_IN_BASE_HI  = 8'h04;
  localparam logic [7:0] OFS_IN_WRPTR    = 8'h08;
  localparam logic [7:0] OFS_RING_CFG    = 8'h0C;
  localparam logic [7:0] OFS_OUT_BASE_LO = 8'h10;
  localparam logic [7:0] OFS_OUT_BASE_HI = 8'h14;
  localparam logic [7:0] OFS_SHD_LO      = 8'h18;
  localparam logic [7:0] OFS_SHD_HI      = 8'h1C;
  localparam logic [7:0] OFS_HOST_RD     = 8'h20;
  localparam logic [7:0] OFS_IRQ_CAUSE   = 8'h24;
  localparam logic [7:0] OFS_IRQ_EN      = 8'h28;
  localparam logic [7:0] OFS_MSG_IN      = 8'h2C;
  localparam logic [7:0] OFS_MSG_OUT     = 8'h30;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDREQ, ST_RDWAIT, ST_ISSUE, ST_WAITSP, ST_WRENT, ST_WRSHD
  } ringState_t;

  typedef struct packed {
    logic loadEntry;
    logic takeCpl;
    logic wrEntry;
    logic wrShadow;
  } ringStrobe_t;
endpackage

// File: rtl/req_ring_fsm.sv
`timescale 1ns/1ps
module req_ring_fsm
  import req_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pending,
  input  logic        full,
  input  logic        memRdValid,
  input  logic        cplValid,
  output logic        memRdEn,
  output logic        reqValid,
  output ringStrobe_t strobe
);
  ringState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (pending)    stateNext = ST_RDREQ;
      ST_RDREQ:                  stateNext = ST_RDWAIT;
      ST_RDWAIT: if (memRdValid) stateNext = ST_ISSUE;
      ST_ISSUE:  if (cplValid)   stateNext = ST_WAITSP;
      ST_WAITSP: if (!full)      stateNext = ST_WRENT;
      ST_WRENT:                  stateNext = ST_WRSHD;
      ST_WRSHD:                  stateNext = ST_IDLE;
      default:                   stateNext = ST_IDLE;
    endcase
  end

  assign memRdEn          = (state == ST_RDREQ);
  assign reqValid         = (state == ST_ISSUE);
  assign strobe.loadEntry = (state == ST_RDWAIT) && memRdValid;
  assign strobe.takeCpl   = (state == ST_ISSUE) && cplValid;
  assign strobe.wrEntry   = (state == ST_WRENT);
  assign strobe.wrShadow  = (state == ST_WRSHD);
endmodule

// File: rtl/req_ring_dp.sv
`timescale 1ns/1ps
module req_ring_dp
  import req_ring_pkg::*;
#(
  parameter int          IDX_W     = 4,
  parameter logic [31:0] HOST_MASK = 32'hC000_0000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  ringStrobe_t      strobe,
  output logic [63:0]      memRdAddr,
  input  logic [63:0]      memRdData,
  output logic [IDX_W-1:0] reqIdx,
  output logic [31:0]      reqAddr,
  output logic [31:0]      reqSize,
  input  logic [31:0]      cplFlag,
  output logic             memWrEn,
  output logic [63:0]      memWrAddr,
  output logic [31:0]      memWrData,
  output logic             cpuMsgValid,
  output logic [31:0]      cpuMsgData,
  input  logic             cpuRplWe,
  input  logic [31:0]      cpuRplData,
  output logic             irq,
  output logic             pending,
  output logic             full
);
  localparam int CNT_W = IDX_W + 1;

  logic [63:0]      inBase, outBase, shdAddr;
  logic [IDX_W-1:0] wrPtr, inLast, outLast, hostRd, inNext, outNext, cfgLast;
  logic [CNT_W-1:0] ringCnt;
  logic             ringEn, msgStrobe, cfgWr;
  logic [1:0]       cause, causeEn, causeSet, causeClr;
  logic [31:0]      msgIn, msgOut, entAddr, entSize, cplWord;

  function automatic logic [IDX_W-1:0] wrapInc(input logic [IDX_W-1:0] idx,
                                                input logic [CNT_W-1:0] cnt);
    logic [CNT_W-1:0] bumped;
    bumped = CNT_W'(idx) + CNT_W'(1);
    return (bumped >= cnt) ? '0 : bumped[IDX_W-1:0];
  endfunction

  assign inNext  = wrapInc(inLast, ringCnt);
  assign outNext = wrapInc(outLast, ringCnt);
  assign cfgWr   = regWe && (regAddr == OFS_RING_CFG);
  assign cfgLast = regWdata[IDX_W-1:0] - IDX_W'(1);

  // Host-visible configuration and base registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBase <= '0; outBase <= '0; shdAddr <= '0;
      ringEn <= 1'b0; ringCnt <= '0; causeEn <= '0;
      msgIn <= '0; msgStrobe <= 1'b0;
    end else begin
      msgStrobe <= 1'b0;
      if (regWe) begin
        unique case (regAddr)
          OFS_IN_BASE_LO:  inBase[31:0]   <= regWdata;
          OFS_IN_BASE_HI:  inBase[63:32]  <= regWdata;
          OFS_OUT_BASE_LO: outBase[31:0]  <= regWdata;
          OFS_OUT_BASE_HI: outBase[63:32] <= regWdata;
          OFS_SHD_LO:      shdAddr[31:0]  <= regWdata;
          OFS_SHD_HI:      shdAddr[63:32] <= regWdata;
          OFS_RING_CFG: begin
            ringEn  <= regWdata[31];
            ringCnt <= regWdata[CNT_W-1:0];
          end
          OFS_IRQ_EN: causeEn <= regWdata[1:0];
          OFS_MSG_IN: begin
            msgIn     <= regWdata;
            msgStrobe <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // Ring indices: strobe updates first, a configuration write overrides
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0; inLast <= '0; outLast <= '0; hostRd <= '0;
    end else begin
      if (regWe && regAddr == OFS_IN_WRPTR) wrPtr  <= regWdata[IDX_W-1:0];
      if (regWe && regAddr == OFS_HOST_RD)  hostRd <= regWdata[IDX_W-1:0];
      if (strobe.takeCpl) inLast  <= inNext;
      if (strobe.wrEntry) outLast <= outNext;
      if (cfgWr) begin
        wrPtr <= cfgLast; inLast <= cfgLast; outLast <= cfgLast; hostRd <= cfgLast;
      end
    end
  end

  // Descriptor and completion capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entAddr <= '0; entSize <= '0; cplWord <= '0;
    end else begin
      if (strobe.loadEntry) {entSize, entAddr} <= memRdData;
      if (strobe.takeCpl)   cplWord <= cplFlag | HOST_MASK;
    end
  end

  // Interrupt cause: set wins over a same-cycle clear
  assign causeSet = {cpuRplWe && (cpuRplData == msgIn), strobe.wrShadow};
  assign causeClr = (regWe && regAddr == OFS_IRQ_CAUSE) ? regWdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cause  <= '0;
      msgOut <= '0;
    end else begin
      cause <= (cause & ~causeClr) | causeSet;
      if (cpuRplWe) msgOut <= cpuRplData;
    end
  end

  always_comb begin
    unique case (regAddr)
      OFS_IN_BASE_LO:  regRdata = inBase[31:0];
      OFS_IN_BASE_HI:  regRdata = inBase[63:32];
      OFS_IN_WRPTR:    regRdata = 32'(wrPtr);
      OFS_RING_CFG:    regRdata = {ringEn, 31'(ringCnt)};
      OFS_OUT_BASE_LO: regRdata = outBase[31:0];
      OFS_OUT_BASE_HI: regRdata = outBase[63:32];
      OFS_SHD_LO:      regRdata = shdAddr[31:0];
      OFS_SHD_HI:      regRdata = shdAddr[63:32];
      OFS_HOST_RD:     regRdata = 32'(hostRd);
      OFS_IRQ_CAUSE:   regRdata = 32'(cause);
      OFS_IRQ_EN:      regRdata = 32'(causeEn);
      OFS_MSG_IN:      regRdata = msgIn;
      OFS_MSG_OUT:     regRdata = msgOut;
      default:         regRdata = '0;
    endcase
  end

  assign pending     = ringEn && (wrPtr != inLast);
  assign full        = (outNext == hostRd);
  assign memRdAddr   = inBase + (64'(inNext) << 3);
  assign reqIdx      = inNext;
  assign reqAddr     = entAddr;
  assign reqSize     = entSize;
  assign memWrEn     = strobe.wrEntry | strobe.wrShadow;
  assign memWrAddr   = strobe.wrShadow ? shdAddr : outBase + (64'(outNext) << 2);
  assign memWrData   = strobe.wrShadow ? 32'(outLast) : cplWord;
  assign cpuMsgValid = msgStrobe;
  assign cpuMsgData  = msgIn;
  assign irq         = |(cause & causeEn);
endmodule

// File: rtl/req_ring_ctl.sv
`timescale 1ns/1ps
module req_ring_ctl
  import req_ring_pkg::*;
#(
  parameter int          IDX_W     = 4,
  parameter logic [31:0] HOST_MASK = 32'hC000_0000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [7:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  output logic             memRdEn,
  output logic [63:0]      memRdAddr,
  input  logic             memRdValid,
  input  logic [63:0]      memRdData,
  output logic             reqValid,
  output logic [IDX_W-1:0] reqIdx,
  output logic [31:0]      reqAddr,
  output logic [31:0]      reqSize,
  input  logic             cplValid,
  input  logic [31:0]      cplFlag,
  output logic             memWrEn,
  output logic [63:0]      memWrAddr,
  output logic [31:0]      memWrData,
  output logic             cpuMsgValid,
  output logic [31:0]      cpuMsgData,
  input  logic             cpuRplWe,
  input  logic [31:0]      cpuRplData,
  output logic             irq
);
  ringStrobe_t strobe;
  logic        pending, full;

  req_ring_fsm u_fsm (
    .clk(clk), .rstN(rstN), .pending(pending), .full(full),
    .memRdValid(memRdValid), .cplValid(cplValid),
    .memRdEn(memRdEn), .reqValid(reqValid), .strobe(strobe)
  );

  req_ring_dp #(.IDX_W(IDX_W), .HOST_MASK(HOST_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strobe(strobe),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .reqIdx(reqIdx),
    .reqAddr(reqAddr), .reqSize(reqSize), .cplFlag(cplFlag),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .cpuMsgValid(cpuMsgValid), .cpuMsgData(cpuMsgData),
    .cpuRplWe(cpuRplWe), .cpuRplData(cpuRplData), .irq(irq),
    .pending(pending), .full(full)
  );
endmodule

// File: rtl/req_ring_chk.sv
`timescale 1ns/1ps
module req_ring_chk
  import req_ring_pkg::*;
#(
  parameter int          IDX_W     = 4,
  parameter logic [31:0] HOST_MASK = 32'hC000_0000
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWe,
  input logic [7:0]       regAddr,
  input logic             memRdEn,
  input logic             memWrEn,
  input logic [31:0]      memWrData,
  input logic             reqValid,
  input logic [IDX_W-1:0] reqIdx,
  input logic [31:0]      reqAddr,
  input logic             cplValid,
  input logic             cpuRplWe,
  input logic             cpuMsgValid,
  input logic             irq
);
  // R3
  single_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (!memRdEn && !memWrEn));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !cplValid) |=> (reqValid && $stable(reqIdx) && $stable(reqAddr)));

  // R5
  host_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !$past(memWrEn)) |-> ((memWrData & HOST_MASK) == HOST_MASK));

  // R6
  shadow_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && !$past(memWrEn)) |=> memWrEn);

  // R6
  write_pair_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && $past(memWrEn)) |=> !memWrEn);

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(memWrEn || cpuRplWe || regWe));

  // R9
  msg_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuMsgValid |-> $past(regWe && (regAddr == OFS_MSG_IN)));
endmodule

bind req_ring_ctl req_ring_chk #(.IDX_W(IDX_W), .HOST_MASK(HOST_MASK)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .memRdEn(memRdEn), .memWrEn(memWrEn), .memWrData(memWrData),
  .reqValid(reqValid), .reqIdx(reqIdx), .reqAddr(reqAddr),
  .cplValid(cplValid), .cpuRplWe(cpuRplWe), .cpuMsgValid(cpuMsgValid),
  .irq(irq)
);

// File: tb/req_ring_ctl_bench.sv
`timescale 1ns/1ps
module req_ring_ctl_bench;
  import req_ring_pkg::*;
  localparam int          IDX_W     = 4;
  localparam logic [31:0] HOST_MASK = 32'hC000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic memRdEn, reqValid, memWrEn, cpuMsgValid, irq;
  logic [63:0] memRdAddr, memWrAddr;
  logic memRdValid = 1'b0;
  logic [63:0] memRdData = '0;
  logic [IDX_W-1:0] reqIdx;
  logic [31:0] reqAddr, reqSize, memWrData, cpuMsgData;
  logic cplValid = 1'b0;
  logic [31:0] cplFlag = '0;
  logic cpuRplWe = 1'b0;
  logic [31:0] cpuRplData = '0;

  always #2 clk = ~clk;

  req_ring_ctl #(.IDX_W(IDX_W), .HOST_MASK(HOST_MASK)) u_req_ring_ctl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdValid(memRdValid), .memRdData(memRdData),
    .reqValid(reqValid), .reqIdx(reqIdx), .reqAddr(reqAddr), .reqSize(reqSize),
    .cplValid(cplValid), .cplFlag(cplFlag), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .cpuMsgValid(cpuMsgValid),
    .cpuMsgData(cpuMsgData), .cpuRplWe(cpuRplWe), .cpuRplData(cpuRplData),
    .irq(irq)
  );

  int nChecks = 0;
  int nFails = 0;

  task automatic checkEq(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural model state
  int cntM = 0, wpM = 0, hostRdM = 0, slotM = 0, obsOut = 0;
  bit enM = 0, msgExp = 0;
  logic [63:0] inBaseM = '0, outBaseM = '0, shdM = '0;
  logic [1:0] causeM = '0, ieM = '0;
  logic [31:0] msgM = '0;
  int qFetch[$];
  logic [63:0] qWrA[$];
  logic [31:0] qWrD[$];
  bit qWrE[$];
  int rdTimer = 0, rdIdx = 0, cplTimer = 0, reqIdxSeen = 0;
  bit reqSeen = 0;
  int rdCount = 0, entWrCount = 0;

  function automatic int nxt(int i);
    return (i + 1 >= cntM) ? 0 : i + 1;
  endfunction

  function automatic logic [63:0] entryOf(int i);
    return {32'h40 + 32'(i), 32'h1000_0000 + 32'(i * 32)};
  endfunction

  always @(negedge clk) begin
    if (rstN) begin
      logic [1:0] setB, clrB;
      setB = 2'b00;
      clrB = 2'b00;
      // R8: interrupt level from the model's cause and enable
      checkEq("R8", "irq", 64'(irq), 64'(|(causeM & ieM)));
      // R9: message strobe due one cycle after the write
      if (msgExp || cpuMsgValid) begin
        checkEq("R9", "cpuMsgValid", 64'(cpuMsgValid), 64'(msgExp));
        if (msgExp) checkEq("R9", "cpuMsgData", 64'(cpuMsgData), 64'(msgM));
        msgExp = 0;
      end
      // descriptor memory responder, two cycles after the request
      if (rdTimer == 1) begin
        memRdValid = 1'b1;
        memRdData  = entryOf(rdIdx);
      end else begin
        memRdValid = 1'b0;
      end
      if (rdTimer > 0) rdTimer--;
      if (memRdEn) begin
        rdCount++;
        if (!enM || qFetch.size() == 0) begin
          checkEq("R10", "unexpected fetch", 64'(memRdEn), 64'd0);
        end else begin
          rdIdx = qFetch.pop_front();
          checkEq("R3", "fetch address", memRdAddr, inBaseM + 64'(rdIdx * 8));
          rdTimer = 2;
        end
      end
      // completion model responder, three cycles after the request
      if (!reqValid) reqSeen = 0;
      if (cplTimer == 1) begin
        cplValid = 1'b1;
        cplFlag  = 32'h0000_5A00 | 32'(reqIdxSeen);
        slotM    = nxt(slotM);
        qWrA.push_back(outBaseM + 64'(slotM * 4));
        qWrD.push_back(cplFlag | HOST_MASK);
        qWrE.push_back(1'b1);
        qWrA.push_back(shdM);
        qWrD.push_back(32'(slotM));
        qWrE.push_back(1'b0);
      end else begin
        cplValid = 1'b0;
      end
      if (cplTimer > 0) cplTimer--;
      if (reqValid && !reqSeen) begin
        reqSeen = 1;
        reqIdxSeen = int'(reqIdx);
        checkEq("R4", "reqIdx", 64'(reqIdx), 64'(rdIdx));
        checkEq("R4", "reqAddr", 64'(reqAddr), 64'(entryOf(rdIdx) & 64'hFFFF_FFFF));
        checkEq("R4", "reqSize", 64'(reqSize), entryOf(rdIdx) >> 32);
        cplTimer = 3;
      end
      // host memory writes
      if (memWrEn) begin
        if (qWrA.size() == 0) begin
          checkEq("R5", "unexpected write", 64'(memWrEn), 64'd0);
        end else begin
          logic [63:0] ea;
          logic [31:0] ed;
          bit ee;
          ea = qWrA.pop_front();
          ed = qWrD.pop_front();
          ee = qWrE.pop_front();
          if (ee) begin
            checkEq("R5", "entry address", memWrAddr, ea);
            checkEq("R5", "entry data", 64'(memWrData), 64'(ed));
            checkEq("R7", "write into full ring", 64'(nxt(obsOut) == hostRdM), 64'd0);
            obsOut = nxt(obsOut);
            entWrCount++;
          end else begin
            checkEq("R6", "shadow address", memWrAddr, ea);
            checkEq("R6", "shadow data", 64'(memWrData), 64'(ed));
            setB[0] = 1'b1;
          end
        end
      end
      if (cpuRplWe && cpuRplData == msgM) setB[1] = 1'b1;
      if (regWe) begin
        case (regAddr)
          OFS_IN_BASE_LO:  inBaseM[31:0]   = regWdata;
          OFS_IN_BASE_HI:  inBaseM[63:32]  = regWdata;
          OFS_OUT_BASE_LO: outBaseM[31:0]  = regWdata;
          OFS_OUT_BASE_HI: outBaseM[63:32] = regWdata;
          OFS_SHD_LO:      shdM[31:0]      = regWdata;
          OFS_SHD_HI:      shdM[63:32]     = regWdata;
          OFS_RING_CFG: begin
            cntM = int'(regWdata[IDX_W:0]);
            enM  = regWdata[31];
            wpM = (cntM + 15) % 16; hostRdM = wpM; slotM = wpM; obsOut = wpM;
            qFetch.delete();
          end
          OFS_IN_WRPTR: begin
            for (int k = 0; k < 64 && wpM != int'(regWdata[IDX_W-1:0]); k++) begin
              wpM = nxt(wpM);
              qFetch.push_back(wpM);
            end
          end
          OFS_HOST_RD:   hostRdM = int'(regWdata[IDX_W-1:0]);
          OFS_IRQ_CAUSE: clrB = regWdata[1:0];
          OFS_IRQ_EN:    ieM = regWdata[1:0];
          OFS_MSG_IN: begin msgM = regWdata; msgExp = 1; end
          default: ;
        endcase
      end
      causeM = (causeM & ~clrB) | setB;
    end
  end

  task automatic wrReg(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWe = 1'b0;
  endtask

  task automatic rdReg(string req, logic [7:0] a, logic [31:0] exp);
    @(posedge clk); #1;
    regAddr = a;
    @(negedge clk);
    checkEq(req, "register read", 64'(regRdata), 64'(exp));
  endtask

  task automatic cpuReply(logic [31:0] d);
    @(posedge clk); #1;
    cpuRplWe = 1'b1; cpuRplData = d;
    @(posedge clk); #1;
    cpuRplWe = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: quiet after reset
    @(negedge clk);
    checkEq("R1", "memRdEn", 64'(memRdEn), 64'd0);
    checkEq("R1", "memWrEn", 64'(memWrEn), 64'd0);
    checkEq("R1", "reqValid", 64'(reqValid), 64'd0);
    checkEq("R1", "irq", 64'(irq), 64'd0);
    rdReg("R1", OFS_IN_WRPTR, 32'd0);
    rdReg("R1", OFS_IRQ_CAUSE, 32'd0);

    // R2/R3/R5/R6: eight-entry ring, three descriptors
    wrReg(OFS_IN_BASE_LO, 32'h0000_8000);
    wrReg(OFS_IN_BASE_HI, 32'h0000_0001);
    wrReg(OFS_OUT_BASE_LO, 32'h0000_C000);
    wrReg(OFS_SHD_LO, 32'h0000_F000);
    wrReg(OFS_IRQ_EN, 32'h1);
    wrReg(OFS_RING_CFG, 32'h8000_0008);
    rdReg("R2", OFS_IN_WRPTR, 32'd7);
    rdReg("R2", OFS_HOST_RD, 32'd7);
    wrReg(OFS_IN_WRPTR, 32'd2);
    repeat (80) @(posedge clk);
    checkEq("R3", "fetch queue drained", 64'(qFetch.size()), 64'd0);
    checkEq("R5", "write queue drained", 64'(qWrA.size()), 64'd0);
    rdReg("R8", OFS_IRQ_CAUSE, 32'd1);
    wrReg(OFS_IRQ_CAUSE, 32'h1);
    rdReg("R8", OFS_IRQ_CAUSE, 32'd0);

    // R7: four-entry ring fills, stalls, then resumes; then wraps
    wrReg(OFS_RING_CFG, 32'h8000_0004);
    base = entWrCount;
    wrReg(OFS_IN_WRPTR, 32'd2);
    wrReg(OFS_IN_WRPTR, 32'd3);
    repeat (80) @(posedge clk);
    checkEq("R7", "entries written while full", 64'(entWrCount - base), 64'd3);
    wrReg(OFS_HOST_RD, 32'd0);
    repeat (40) @(posedge clk);
    checkEq("R7", "entries after host advanced", 64'(entWrCount - base), 64'd4);
    wrReg(OFS_HOST_RD, 32'd3);
    wrReg(OFS_IN_WRPTR, 32'd1);
    repeat (60) @(posedge clk);
    checkEq("R3", "wrapped fetches drained", 64'(qFetch.size()), 64'd0);
    checkEq("R5", "wrapped writes drained", 64'(qWrA.size()), 64'd0);
    checkEq("R7", "entries after wrap", 64'(entWrCount - base), 64'd6);

    // R10: disabled ring ignores the write pointer
    wrReg(OFS_RING_CFG, 32'h0000_0004);
    base = rdCount;
    wrReg(OFS_IN_WRPTR, 32'd1);
    repeat (30) @(posedge clk);
    checkEq("R10", "fetches while disabled", 64'(rdCount - base), 64'd0);
    wrReg(OFS_RING_CFG, 32'h8000_0004);

    // R9/R8: mailbox round trip
    wrReg(OFS_IRQ_CAUSE, 32'h3);
    wrReg(OFS_IRQ_EN, 32'h2);
    wrReg(OFS_MSG_IN, 32'h1234_5678);
    rdReg("R9", OFS_MSG_IN, 32'h1234_5678);
    cpuReply(32'h0000_1111);
    rdReg("R8", OFS_IRQ_CAUSE, 32'd0);
    rdReg("R9", OFS_MSG_OUT, 32'h0000_1111);
    cpuReply(32'h1234_5678);
    rdReg("R8", OFS_IRQ_CAUSE, 32'd2);
    rdReg("R9", OFS_MSG_OUT, 32'h1234_5678);
    wrReg(OFS_IRQ_CAUSE, 32'h2);
    repeat (5) @(posedge clk);
    rdReg("R8", OFS_IRQ_CAUSE, 32'd0);
    finishRun();
  end
endmodule